// File: doc/BRIEF.md
# Trace-Write Instruction Decoder and Packet Emitter

This block takes one instruction at a time from an instruction stream that has already been split at instruction boundaries. It decides whether the instruction is the software trace-write form: a mandatory repeat prefix, the two opcode bytes 0F and AE, and a register-form ModRM byte whose reg field selects 4. For that form it either raises an undefined-opcode fault or turns the register operand into trace output. The output is a data packet, which may be followed by an address packet that carries the instruction's own address. Instructions that do not match are consumed silently.

Instructions arrive on a valid/ready intake. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both 1. Packets leave on a valid/ready output. A packet stays on `pkt_*` without change until it is taken on an edge where `pkt_valid` and `pkt_ready` are both 1. While any packet from an instruction is still pending, `in_ready` is held at 0. Back-pressure from the trace sink therefore stalls the intake, and no packet is ever dropped. The fault strobe is a plain one-cycle pulse with no handshake. The block has no condition-flag outputs, so it never changes architectural flags.

Top module: `trcw_unit`

## Requirements
- R1: An instruction matches only when all of the following hold: `pfx_rep`=1, `ins_esc`=0x0F, `ins_grp`=0xAE, ModRM bits [7:6]=2'b11 and ModRM bits [5:3]=4. Any other taken instruction gives no fault and no packet.
- R2: A matching instruction with `pfx_opsz`=1 raises `ud_fault` and produces no packet.
- R3: A matching instruction with `pfx_lock`=1 raises `ud_fault` and produces no packet.
- R4: A matching instruction with `feat_en`=0 raises `ud_fault` and produces no packet.
- R5: A fault takes priority: when a fault condition holds, no packet is produced even if all four qualifiers are 1.
- R6: A matching, non-faulting instruction produces a data packet only when `qual_trig`, `qual_ctx`, `qual_filt` and `qual_wren` are all 1. If any of them is 0 there is neither a packet nor a fault.
- R7: The data packet has `pkt_is_addr`=0. It is 8 bytes only when `pfx_rexw`=1 and `mode64`=1, in which case `pkt_size8`=1 and the body is the full operand. In every other case `pkt_size8`=0, the body holds the operand's low 32 bits, and the upper 32 bits are zero.
- R8: The data packet's `pkt_ipflag` equals `ip_ins`. When `ip_ins`=1, the next packet is an address packet with `pkt_is_addr`=1, `pkt_size8`=1, `pkt_ipflag`=0 and body = `ins_addr`. When `ip_ins`=0, no address packet follows.
- R9: While `pkt_valid`=1 and `pkt_ready`=0, every `pkt_*` output holds its value and `in_ready`=0. `in_ready` returns to 1 once the last packet of the instruction has been taken.
- R10: `ud_fault` and the data packet's `pkt_valid` appear in the cycle that follows the edge on which the instruction was taken. `ud_fault` lasts one cycle.
- R11: After reset, `in_ready`=1, `pkt_valid`=0 and `ud_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction |
| ins_esc | input | 8 | First opcode byte after prefixes |
| ins_grp | input | 8 | Second opcode byte |
| ins_modrm | input | 8 | ModRM byte |
| pfx_rep | input | 1 | Repeat (F3) prefix present |
| pfx_opsz | input | 1 | Operand-size (66) prefix present |
| pfx_lock | input | 1 | Lock prefix present |
| pfx_rexw | input | 1 | REX prefix with W=1 present |
| mode64 | input | 1 | Core is in 64-bit mode |
| feat_en | input | 1 | Trace-write feature supported |
| qual_trig | input | 1 | Trigger qualifier |
| qual_ctx | input | 1 | Context qualifier |
| qual_filt | input | 1 | Filter qualifier |
| qual_wren | input | 1 | Trace-write enable qualifier |
| ip_ins | input | 1 | Insert an address packet after the data |
| operand | input | 64 | Source register value |
| ins_addr | input | 64 | Address of the instruction |
| ud_fault | output | 1 | Undefined-opcode fault pulse |
| pkt_valid | output | 1 | Packet present |
| pkt_ready | input | 1 | Sink accepts the packet |
| pkt_is_addr | output | 1 | 1 for an address packet, 0 for a data packet |
| pkt_size8 | output | 1 | Payload size: 0 = 4 bytes, 1 = 8 bytes |
| pkt_ipflag | output | 1 | Data packet flag: an address packet follows |
| pkt_body | output | 64 | Packet payload |

## Verification
The assertions check four things on every cycle. A pending packet is held stable under back-pressure. A fault pulse never coincides with a packet. An accepted data packet with its flag set is always followed by an address packet. The decoder never reports fault and emit together. The bench's sweeps are needed for everything that depends on the input mix: which encodings match, which prefix or feature combinations fault, the AND of the qualifiers, and the choice of payload width with its zero-filled upper half. The sweeps also exercise stalls of varying length to show that the intake stays closed until the last packet leaves.

// File: rtl/trcw_pkg.sv
package trcw_pkg;
  localparam logic [7:0] OPC_ESC = 8'h0F;
  localparam logic [7:0] OPC_GRP = 8'hAE;
  localparam logic [1:0] MOD_REG = 2'b11;
  localparam logic [2:0] REG_SEL = 3'd4;

  typedef enum logic [1:0] {
    EM_IDLE = 2'd0,
    EM_DATA = 2'd1,
    EM_ADDR = 2'd2
  } em_state_t;

  typedef struct packed {
    logic fault;
    logic emit;
    logic wide;
    logic ip_ins;
  } dec_res_t;
endpackage

// File: rtl/trcw_decode.sv
module trcw_decode
  import trcw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NQUAL  = 4
) (
  input  logic [7:0]        esc,
  input  logic [7:0]        grp,
  input  logic [7:0]        modrm,
  input  logic              pfx_rep,
  input  logic              pfx_opsz,
  input  logic              pfx_lock,
  input  logic              pfx_rexw,
  input  logic              mode64,
  input  logic              feat_en,
  input  logic [NQUAL-1:0]  quals,
  input  logic              ip_ins,
  input  logic [DATA_W-1:0] operand,
  output dec_res_t          res,
  output logic [DATA_W-1:0] payload
);
  localparam int HALF_W = DATA_W / 2;

  logic match;
  logic illegal;
  logic unused_rm;

  // register selector bits are resolved upstream; operand already carries the value
  assign unused_rm = ^modrm[2:0];

  always_comb begin
    match   = pfx_rep && (esc == OPC_ESC) && (grp == OPC_GRP)
              && (modrm[7:6] == MOD_REG) && (modrm[5:3] == REG_SEL);
    illegal = pfx_opsz || pfx_lock || !feat_en;
    res.fault  = match && illegal;
    res.emit   = match && !illegal && (&quals);
    res.wide   = pfx_rexw && mode64;
    res.ip_ins = ip_ins;
  end

  always_comb begin
    payload = '0;
    if (res.wide) payload = operand;
    else          payload[HALF_W-1:0] = operand[HALF_W-1:0];
  end
endmodule

// File: rtl/trcw_emit.sv
module trcw_emit
  import trcw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  dec_res_t          res,
  input  logic [DATA_W-1:0] payload,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_ready,
  output logic              ud_fault,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic              pkt_is_addr,
  output logic              pkt_size8,
  output logic              pkt_ipflag,
  output logic [PKT_W-1:0]  pkt_body
);
  localparam int PKT_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;

  em_state_t         state;
  logic [ADDR_W-1:0] addr_q;
  logic              fault_q;

  assign in_ready  = (state == EM_IDLE);
  assign pkt_valid = (state != EM_IDLE);
  assign ud_fault  = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= EM_IDLE;
      fault_q     <= 1'b0;
      addr_q      <= '0;
      pkt_body    <= '0;
      pkt_is_addr <= 1'b0;
      pkt_size8   <= 1'b0;
      pkt_ipflag  <= 1'b0;
    end else begin
      fault_q <= accept && res.fault;
      unique case (state)
        EM_IDLE: begin
          if (accept && res.emit) begin
            pkt_body              <= '0;
            pkt_body[DATA_W-1:0]  <= payload;
            pkt_is_addr           <= 1'b0;
            pkt_size8             <= res.wide;
            pkt_ipflag            <= res.ip_ins;
            addr_q                <= addr;
            state                 <= EM_DATA;
          end
        end
        EM_DATA: begin
          if (pkt_ready) begin
            if (pkt_ipflag) begin
              pkt_body             <= '0;
              pkt_body[ADDR_W-1:0] <= addr_q;
              pkt_is_addr          <= 1'b1;
              pkt_size8            <= 1'b1;
              pkt_ipflag           <= 1'b0;
              state                <= EM_ADDR;
            end else begin
              state <= EM_IDLE;
            end
          end
        end
        EM_ADDR: begin
          if (pkt_ready) state <= EM_IDLE;
        end
        default: state <= EM_IDLE;
      endcase
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_body)
      && $stable(pkt_is_addr) && $stable(pkt_size8) && $stable(pkt_ipflag));

  p_fault_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> !pkt_valid);

  p_addr_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_ready && !pkt_is_addr && pkt_ipflag |=> pkt_valid && pkt_is_addr);

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !(res.fault && res.emit));
endmodule

// File: rtl/trcw_unit.sv
module trcw_unit
  import trcw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        ins_esc,
  input  logic [7:0]        ins_grp,
  input  logic [7:0]        ins_modrm,
  input  logic              pfx_rep,
  input  logic              pfx_opsz,
  input  logic              pfx_lock,
  input  logic              pfx_rexw,
  input  logic              mode64,
  input  logic              feat_en,
  input  logic              qual_trig,
  input  logic              qual_ctx,
  input  logic              qual_filt,
  input  logic              qual_wren,
  input  logic              ip_ins,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] ins_addr,
  output logic              ud_fault,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic              pkt_is_addr,
  output logic              pkt_size8,
  output logic              pkt_ipflag,
  output logic [PKT_W-1:0]  pkt_body
);
  localparam int PKT_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int NQUAL = 4;

  dec_res_t          res;
  logic [DATA_W-1:0] payload;
  logic              accept;

  assign accept = in_valid && in_ready;

  trcw_decode #(.DATA_W(DATA_W), .NQUAL(NQUAL)) u_dec (
    .esc      (ins_esc),
    .grp      (ins_grp),
    .modrm    (ins_modrm),
    .pfx_rep  (pfx_rep),
    .pfx_opsz (pfx_opsz),
    .pfx_lock (pfx_lock),
    .pfx_rexw (pfx_rexw),
    .mode64   (mode64),
    .feat_en  (feat_en),
    .quals    ({qual_trig, qual_ctx, qual_filt, qual_wren}),
    .ip_ins   (ip_ins),
    .operand  (operand),
    .res      (res),
    .payload  (payload)
  );

  trcw_emit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .res         (res),
    .payload     (payload),
    .addr        (ins_addr),
    .in_ready    (in_ready),
    .ud_fault    (ud_fault),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .pkt_is_addr (pkt_is_addr),
    .pkt_size8   (pkt_size8),
    .pkt_ipflag  (pkt_ipflag),
    .pkt_body    (pkt_body)
  );

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pkt_valid |-> !in_ready);
endmodule

// File: tb/tb_trcw_unit.sv
module tb_trcw_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] ins_esc = '0, ins_grp = '0, ins_modrm = '0;
  logic pfx_rep = 0, pfx_opsz = 0, pfx_lock = 0, pfx_rexw = 0, mode64 = 0, feat_en = 0;
  logic qual_trig = 0, qual_ctx = 0, qual_filt = 0, qual_wren = 0, ip_ins = 0;
  logic [63:0] operand = '0, ins_addr = '0;
  logic ud_fault, pkt_valid, pkt_ready = 1'b0, pkt_is_addr, pkt_size8, pkt_ipflag;
  logic [63:0] pkt_body;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  trcw_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ins_esc(ins_esc), .ins_grp(ins_grp), .ins_modrm(ins_modrm),
    .pfx_rep(pfx_rep), .pfx_opsz(pfx_opsz), .pfx_lock(pfx_lock), .pfx_rexw(pfx_rexw),
    .mode64(mode64), .feat_en(feat_en), .qual_trig(qual_trig), .qual_ctx(qual_ctx),
    .qual_filt(qual_filt), .qual_wren(qual_wren), .ip_ins(ip_ins),
    .operand(operand), .ins_addr(ins_addr), .ud_fault(ud_fault),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_is_addr(pkt_is_addr),
    .pkt_size8(pkt_size8), .pkt_ipflag(pkt_ipflag), .pkt_body(pkt_body)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // c[0] opsz, c[1] lock, c[2] feat, c[3] mode64, c[4] rexw, c[8:5] quals, c[9] ip_ins
  task automatic run_vec(input logic rep, input logic [7:0] esc, input logic [7:0] grp,
                         input logic [7:0] mrm, input logic [9:0] c, input int idx);
    logic m, f, e, w;
    logic [63:0] op, ad, expb;
    op = {32'hC0DE0000 + idx, 32'h5A5A0000 ^ idx};
    ad = 64'hFFFF_8000_0000_1000 + 64'(idx) * 16;
    @(negedge clk);
    in_valid = 1'b1; pfx_rep = rep; ins_esc = esc; ins_grp = grp; ins_modrm = mrm;
    pfx_opsz = c[0]; pfx_lock = c[1]; feat_en = c[2]; mode64 = c[3]; pfx_rexw = c[4];
    qual_trig = c[5]; qual_ctx = c[6]; qual_filt = c[7]; qual_wren = c[8]; ip_ins = c[9];
    operand = op; ins_addr = ad;
    m = rep && esc == 8'h0F && grp == 8'hAE && mrm[7:6] == 2'b11 && mrm[5:3] == 3'd4;
    f = m && (c[0] || c[1] || !c[2]);
    e = m && !f && (&c[8:5]);
    w = c[3] && c[4];
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(64'(ud_fault), 64'(f), "R1 R2 R3 R4 R10 fault strobe");
    chk(64'(pkt_valid), 64'(e), "R1 R5 R6 R10 data packet valid");
    if (e) begin
      expb = w ? op : {32'h0, op[31:0]};
      chk(pkt_body, expb, "R7 data body");
      chk(64'(pkt_size8), 64'(w), "R7 size field");
      chk(64'(pkt_is_addr), 64'd0, "R7 data kind");
      chk(64'(pkt_ipflag), 64'(c[9]), "R8 ip flag");
      for (int s = 0; s < idx % 3; s++) begin
        @(posedge clk); @(negedge clk);
        chk({62'd0, pkt_valid, in_ready}, 64'd2, "R9 held under stall");
        chk(pkt_body, expb, "R9 body stable");
      end
      pkt_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      pkt_ready = 1'b0;
      chk(64'(ud_fault), 64'd0, "R10 single-cycle fault");
      if (c[9]) begin
        chk({61'd0, pkt_valid, pkt_is_addr, pkt_size8}, 64'd7, "R8 address packet");
        chk(64'(pkt_ipflag), 64'd0, "R8 address ip flag");
        chk(pkt_body, ad, "R8 address body");
        pkt_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        pkt_ready = 1'b0;
      end
      chk({62'd0, pkt_valid, in_ready}, 64'd1, "R9 intake reopened");
    end else begin
      chk(64'(in_ready), 64'd1, "R6 idle after no-emit");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk({61'd0, in_ready, pkt_valid, ud_fault}, 64'd4, "R11 reset state");
    for (int i = 0; i < 1024; i++)
      run_vec(1'b1, 8'h0F, 8'hAE, 8'hE0, 10'(i), i);
    for (int j = 0; j < 64; j++)
      run_vec(1'b1, 8'h0F, 8'hAE, {j[1:0], j[4:2], 3'(j)}, 10'h3E4, j + 2000);
    run_vec(1'b0, 8'h0F, 8'hAE, 8'hE0, 10'h3E4, 3000);
    run_vec(1'b1, 8'h0E, 8'hAE, 8'hE0, 10'h3E4, 3001);
    run_vec(1'b1, 8'h0F, 8'hAF, 8'hE0, 10'h3E4, 3002);
    run_vec(1'b1, 8'h0F, 8'hAE, 8'hE3, 10'h3FC, 3003);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule